// File: doc/BRIEF.md
# Accumulator ALU with Processor Status Register

This block is the arithmetic and logic unit of a small accumulator-based processor, together with the status byte that goes with it. Each clock it takes an operation code, two operands and a software-break marker. One cycle later it presents a registered result and the updated status byte. The carry-in and the decimal-mode selection come from the block's own carry and decimal flags. An instruction sequencer outside the block selects which register feeds each operand and where the result goes.

The operations are:
- add and subtract through carry, in binary or, when the decimal flag is set, in packed BCD;
- the three bitwise logic functions;
- one-bit shifts and rotates through carry;
- compare and bit test, which touch only flags;
- explicit set and clear of single flags;
- loading the status byte from an operand, and producing the byte that is pushed to the stack.

The operand width is a parameter. The arithmetic scales in whole decimal digits, and the status byte is always eight bits.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high reset sets `res_o` to 0 and `status_o` to 8'h24, which has the interrupt-disable bit and bit 5 set.
- R2: The `status_o` bit positions are: 0 carry, 1 zero, 2 interrupt disable, 3 decimal, 4 break, 5 constant, 6 overflow, 7 negative. Bit 5 always reads 1 and bit 4 always reads 0.
- R3: In binary mode, ADC (code 1) gives A+B+C. Carry is the carry out of bit 7, and overflow is set when the signed result leaves -128..127 (64+64 gives 8'h80 with V=1). N copies bit 7 of the result and Z is set when the result is zero.
- R4: In binary mode, SBC (code 2) gives A-B-(1-C). Carry ends up 1 when no borrow occurred. V, N and Z are formed as in R3.
- R5: With the decimal flag set and valid BCD operands, ADC and SBC produce a two-digit packed BCD result. Carry is the decimal carry or the inverted decimal borrow. N and Z follow the corrected result, and V follows the binary computation.
- R6: AND (3), OR (4) and XOR (5) of A and B write the result and set N and Z. C and V are left unchanged.
- R7: The shift and rotate codes all act on A, and each moves the bit shifted out into C:
  - ASL (6) shifts left and fills bit 0 with 0;
  - LSR (7) shifts right, fills bit 7 with 0 and always clears N;
  - ROL (8) shifts left and fills bit 0 with the old C;
  - ROR (9) shifts right and fills bit 7 with the old C.
- R8: CMP (10) sets C when A>=B unsigned, sets Z when A==B, and sets N from bit 7 of A-B. It leaves `res_o` and V unchanged.
- R9: BIT (11) sets Z when (A AND B) is zero and copies B[7] to N and B[6] to V. It leaves `res_o` and C unchanged.
- R10: The single-flag codes change exactly one flag each: SEC (12) and CLC (13) for carry, SEI (14) and CLI (15) for interrupt disable, SED (16) and CLD (17) for decimal, and CLV (18) clears overflow.
- R11: PULL (19) loads C, Z, I, D, V and N from the matching bits of B and discards B[5:4]. It leaves `res_o` unchanged.
- R12: PUSH (20) writes to `res_o` the status byte with bit 5 set and bit 4 equal to `brk_i`. It changes no flag.
- R13: NOP (0) and codes 21..31 change nothing. Every other effect shows on the outputs exactly one clock after the operation is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code (see requirements) |
| a_i | input | DATA_W | Operand A (accumulator side) |
| b_i | input | DATA_W | Operand B (memory side) |
| brk_i | input | 1 | Marks a PUSH as a software break (sets bit 4 of the pushed byte) |
| res_o | output | DATA_W | Registered result |
| status_o | output | 8 | Registered status byte |

## Verification
On every cycle, the embedded assertions check the following:
- the fixed bits and the break bit of a pushed byte;
- that a logical right shift clears N;
- that compare and bit test leave the result alone;
- that compare carry matches the unsigned ordering of its operands;
- that the single-flag controls and PUSH have the expected effect on the flags.

The arithmetic values can only be shown by the bench's scenarios, which compare every cycle against a reference model built on integer and decimal arithmetic. These include:
- the carry, overflow and zero corners of add and subtract;
- BCD wrap-around with carry and borrow;
- rotates that pull in the old carry;
- status loads that try to set bits 4 and 5.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SBC  = 5'd2,
    OP_AND  = 5'd3,
    OP_ORA  = 5'd4,
    OP_EOR  = 5'd5,
    OP_ASL  = 5'd6,
    OP_LSR  = 5'd7,
    OP_ROL  = 5'd8,
    OP_ROR  = 5'd9,
    OP_CMP  = 5'd10,
    OP_BIT  = 5'd11,
    OP_SEC  = 5'd12,
    OP_CLC  = 5'd13,
    OP_SEI  = 5'd14,
    OP_CLI  = 5'd15,
    OP_SED  = 5'd16,
    OP_CLD  = 5'd17,
    OP_CLV  = 5'd18,
    OP_PULL = 5'd19,
    OP_PUSH = 5'd20
  } alu_op_e;

  // Bit positions inside the status byte
  localparam int FLG_C   = 0;
  localparam int FLG_Z   = 1;
  localparam int FLG_I   = 2;
  localparam int FLG_D   = 3;
  localparam int FLG_B   = 4;
  localparam int FLG_ONE = 5;
  localparam int FLG_V   = 6;
  localparam int FLG_N   = 7;

  // Flag values produced by the datapath, plus write enables
  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
    logic nz_we;
    logic v_we;
    logic c_we;
    logic res_we;
  } alu_flags_t;

endpackage

// File: rtl/acc_bcd_digit.sv
module acc_bcd_digit (
  input  logic [3:0] x_i,
  input  logic [3:0] y_i,
  input  logic       sub_i,
  input  logic       carry_i,
  output logic [3:0] dig_o,
  output logic       carry_o
);

  // carry_i/carry_o: for add, 1 = carry; for subtract, 1 = no borrow
  logic [4:0] raw;
  logic       adj;

  always_comb begin
    if (sub_i) begin
      raw = {1'b0, x_i} - {1'b0, y_i} - {4'b0000, ~carry_i};
      adj = raw[4];
      carry_o = ~adj;
      dig_o = adj ? (raw[3:0] - 4'd6) : raw[3:0];
    end else begin
      raw = {1'b0, x_i} + {1'b0, y_i} + {4'b0000, carry_i};
      adj = (raw > 5'd9);
      carry_o = adj;
      dig_o = adj ? (raw[3:0] + 4'd6) : raw[3:0];
    end
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c_i,
  input  logic              d_i,
  output logic [DATA_W-1:0] res_o,
  output alu_flags_t        fl_o
);

  localparam int MSB = DATA_W - 1;
  localparam int NIB = DATA_W / 4;

  // Binary path: subtraction adds the complement
  logic              sub;
  logic [DATA_W-1:0] bb;
  logic [DATA_W:0]   bsum;
  logic              ovf;

  assign sub  = (op_i == OP_SBC);
  assign bb   = sub ? ~b_i : b_i;
  assign bsum = {1'b0, a_i} + {1'b0, bb} + {{DATA_W{1'b0}}, c_i};
  assign ovf  = (a_i[MSB] == bb[MSB]) && (bsum[MSB] != a_i[MSB]);

  // Decimal path: one corrected digit per nibble, carries rippled
  logic [NIB:0]      dc;
  logic [DATA_W-1:0] dsum;

  assign dc[0] = c_i;

  for (genvar g = 0; g < NIB; g++) begin : g_digit
    acc_bcd_digit u_digit (
      .x_i    (a_i[4*g +: 4]),
      .y_i    (b_i[4*g +: 4]),
      .sub_i  (sub),
      .carry_i(dc[g]),
      .dig_o  (dsum[4*g +: 4]),
      .carry_o(dc[g+1])
    );
  end

  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] nzsrc;
  assign diff = a_i - b_i;

  always_comb begin
    res_o = '0;
    fl_o  = '0;
    nzsrc = '0;
    unique case (op_i)
      OP_ADC, OP_SBC: begin
        res_o       = d_i ? dsum : bsum[MSB:0];
        fl_o.c      = d_i ? dc[NIB] : bsum[DATA_W];
        fl_o.v      = ovf;
        fl_o.c_we   = 1'b1;
        fl_o.v_we   = 1'b1;
        fl_o.nz_we  = 1'b1;
        fl_o.res_we = 1'b1;
      end
      OP_AND, OP_ORA, OP_EOR: begin
        res_o       = (op_i == OP_AND) ? (a_i & b_i) :
                      (op_i == OP_ORA) ? (a_i | b_i) : (a_i ^ b_i);
        fl_o.nz_we  = 1'b1;
        fl_o.res_we = 1'b1;
      end
      OP_ASL, OP_ROL: begin
        res_o       = {a_i[MSB-1:0], (op_i == OP_ROL) & c_i};
        fl_o.c      = a_i[MSB];
        fl_o.c_we   = 1'b1;
        fl_o.nz_we  = 1'b1;
        fl_o.res_we = 1'b1;
      end
      OP_LSR, OP_ROR: begin
        res_o       = {(op_i == OP_ROR) & c_i, a_i[MSB:1]};
        fl_o.c      = a_i[0];
        fl_o.c_we   = 1'b1;
        fl_o.nz_we  = 1'b1;
        fl_o.res_we = 1'b1;
      end
      OP_CMP: begin
        fl_o.c     = (a_i >= b_i);
        fl_o.c_we  = 1'b1;
        fl_o.nz_we = 1'b1;
      end
      OP_BIT: begin
        fl_o.v     = b_i[MSB-1];
        fl_o.v_we  = 1'b1;
        fl_o.nz_we = 1'b1;
      end
      default: ;
    endcase

    // N and Z source: the difference for compare, the result otherwise
    nzsrc = (op_i == OP_CMP) ? diff : res_o;
    if (op_i == OP_BIT) begin
      fl_o.n = b_i[MSB];
      fl_o.z = ((a_i & b_i) == '0);
    end else begin
      fl_o.n = nzsrc[MSB];
      fl_o.z = (nzsrc == '0);
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              brk_i,
  output logic [DATA_W-1:0] res_o,
  output logic [7:0]        status_o
);

  alu_op_e           op;
  logic [DATA_W-1:0] alu_res;
  alu_flags_t        fl;
  logic [DATA_W-1:0] res_q;
  logic              f_c, f_z, f_i, f_d, f_v, f_n;
  logic [7:0]        push_byte;

  assign op = alu_op_e'(op_i);

  acc_alu_core #(.DATA_W(DATA_W)) u_core (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .c_i  (f_c),
    .d_i  (f_d),
    .res_o(alu_res),
    .fl_o (fl)
  );

  assign push_byte = {f_n, f_v, 1'b1, brk_i, f_d, f_i, f_z, f_c};

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      f_c   <= 1'b0;
      f_z   <= 1'b0;
      f_i   <= 1'b1;
      f_d   <= 1'b0;
      f_v   <= 1'b0;
      f_n   <= 1'b0;
    end else begin
      if (fl.res_we) res_q <= alu_res;
      if (fl.nz_we) begin
        f_n <= fl.n;
        f_z <= fl.z;
      end
      if (fl.v_we) f_v <= fl.v;
      if (fl.c_we) f_c <= fl.c;
      case (op)
        OP_SEC:  f_c <= 1'b1;
        OP_CLC:  f_c <= 1'b0;
        OP_SEI:  f_i <= 1'b1;
        OP_CLI:  f_i <= 1'b0;
        OP_SED:  f_d <= 1'b1;
        OP_CLD:  f_d <= 1'b0;
        OP_CLV:  f_v <= 1'b0;
        OP_PULL: begin
          f_c <= b_i[FLG_C];
          f_z <= b_i[FLG_Z];
          f_i <= b_i[FLG_I];
          f_d <= b_i[FLG_D];
          f_v <= b_i[FLG_V];
          f_n <= b_i[FLG_N];
        end
        OP_PUSH: res_q <= DATA_W'(push_byte);
        default: ;
      endcase
    end
  end

  assign res_o    = res_q;
  assign status_o = {f_n, f_v, 1'b1, 1'b0, f_d, f_i, f_z, f_c};

  // Pushed copy carries the constant bit and the break marker
  assert_push_byte_R12: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_PUSH) |=> (res_o[FLG_ONE] && (res_o[FLG_B] == $past(brk_i))));

  // Pushing leaves every flag in place
  assert_push_flags_R12: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_PUSH) |=> $stable(status_o));

  assert_lsr_clears_n_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LSR) |=> !status_o[FLG_N]);

  assert_test_keeps_res_R8: assert property (@(posedge clk) disable iff (rst)
    ((op_i == OP_CMP) || (op_i == OP_BIT)) |=> $stable(res_o));

  assert_cmp_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CMP) |=> (status_o[FLG_C] == ($past(a_i) >= $past(b_i))));

  assert_sec_R10: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SEC) |=> status_o[FLG_C]);

  assert_clv_R10: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CLV) |=> !status_o[FLG_V]);

  assert_pull_fixed_R11: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_PULL) |=> (status_o[FLG_ONE] && !status_o[FLG_B]));

endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = 5'd0;
  logic [7:0] a_i = 8'h00;
  logic [7:0] b_i = 8'h00;
  logic       brk_i = 1'b0;
  logic [7:0] res_o;
  logic [7:0] status_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model state
  bit       m_c, m_z, m_i, m_d, m_v, m_n;
  bit [7:0] m_res;

  always #2.5 clk = ~clk;

  acc_alu #(.DATA_W(8)) i_acc_alu (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .brk_i(brk_i), .res_o(res_o), .status_o(status_o)
  );

  function automatic bit [7:0] m_status();
    return {m_n, m_v, 1'b1, 1'b0, m_d, m_i, m_z, m_c};
  endfunction

  function automatic int dec_of(input bit [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  function automatic bit [7:0] bcd_of(input int v);
    bit [3:0] hi = 4'(v / 10);
    bit [3:0] lo = 4'(v % 10);
    return {hi, lo};
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd0: return "R13";
      5'd1: return m_d ? "R5" : "R3";
      5'd2: return m_d ? "R5" : "R4";
      5'd3, 5'd4, 5'd5: return "R6";
      5'd6, 5'd7, 5'd8, 5'd9: return "R7";
      5'd10: return "R8";
      5'd11: return "R9";
      5'd19: return "R11";
      5'd20: return "R12";
      default: return (op >= 5'd21) ? "R13" : "R10";
    endcase
  endfunction

  task automatic set_nz(input bit [7:0] r);
    m_n = r[7];
    m_z = (r == 8'h00);
  endtask

  task automatic model(input logic [4:0] op, input bit [7:0] a, input bit [7:0] b, input bit brk);
    int s, sa, r;
    bit [7:0] t;
    case (op)
      5'd1: begin
        s  = int'(a) + int'(b) + int'(m_c);
        sa = int'($signed(a)) + int'($signed(b)) + int'(m_c);
        m_v = (sa > 127) || (sa < -128);
        if (m_d) begin
          r = dec_of(a) + dec_of(b) + int'(m_c);
          m_c = (r > 99);
          m_res = bcd_of(r % 100);
        end else begin
          m_c = (s > 255);
          m_res = s[7:0];
        end
        set_nz(m_res);
      end
      5'd2: begin
        s  = int'(a) - int'(b) - (1 - int'(m_c));
        sa = int'($signed(a)) - int'($signed(b)) - (1 - int'(m_c));
        m_v = (sa > 127) || (sa < -128);
        if (m_d) begin
          r = dec_of(a) - dec_of(b) - (1 - int'(m_c));
          m_c = (r >= 0);
          m_res = bcd_of((r + 100) % 100);
        end else begin
          m_c = (s >= 0);
          m_res = s[7:0];
        end
        set_nz(m_res);
      end
      5'd3: begin m_res = a & b; set_nz(m_res); end
      5'd4: begin m_res = a | b; set_nz(m_res); end
      5'd5: begin m_res = a ^ b; set_nz(m_res); end
      5'd6: begin m_res = 8'((int'(a) * 2) % 256); m_c = a[7]; set_nz(m_res); end
      5'd7: begin m_res = 8'(int'(a) / 2); m_c = a[0]; set_nz(m_res); end
      5'd8: begin m_res = 8'((int'(a) * 2 + int'(m_c)) % 256); m_c = a[7]; set_nz(m_res); end
      5'd9: begin m_res = 8'(int'(a) / 2 + 128 * int'(m_c)); m_c = a[0]; set_nz(m_res); end
      5'd10: begin
        t = 8'((int'(a) - int'(b) + 256) % 256);
        m_c = (a >= b);
        set_nz(t);
      end
      5'd11: begin m_z = ((a & b) == 8'h00); m_n = b[7]; m_v = b[6]; end
      5'd12: m_c = 1;
      5'd13: m_c = 0;
      5'd14: m_i = 1;
      5'd15: m_i = 0;
      5'd16: m_d = 1;
      5'd17: m_d = 0;
      5'd18: m_v = 0;
      5'd19: begin
        m_c = b[0]; m_z = b[1]; m_i = b[2]; m_d = b[3]; m_v = b[6]; m_n = b[7];
      end
      5'd20: m_res = {m_n, m_v, 1'b1, brk, m_d, m_i, m_z, m_c};
      default: ;
    endcase
  endtask

  task automatic check(input string tag);
    n_run++;
    if (res_o !== m_res || status_o !== m_status()) begin
      n_fail++;
      $display("FAIL %s: res=%h status=%h expected res=%h status=%h",
               tag, res_o, status_o, m_res, m_status());
    end
  endtask

  task automatic step(input logic [4:0] op, input bit [7:0] a, input bit [7:0] b, input bit brk);
    string tag;
    @(negedge clk);
    tag = tag_of(op);
    op_i = op; a_i = a; b_i = b; brk_i = brk;
    model(op, a, b, brk);
    @(posedge clk);
    #1;
    check(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    m_res = 8'h00; m_c = 0; m_z = 0; m_i = 1; m_d = 0; m_v = 0; m_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1");

    // R13: NOP and unused codes
    step(5'd0, 8'hFF, 8'hFF, 1'b1);
    step(5'd25, 8'h12, 8'h34, 1'b0);

    // R10: single-flag controls
    step(5'd12, 8'h00, 8'h00, 1'b0);
    step(5'd15, 8'h00, 8'h00, 1'b0);
    step(5'd16, 8'h00, 8'h00, 1'b0);
    step(5'd17, 8'h00, 8'h00, 1'b0);
    step(5'd14, 8'h00, 8'h00, 1'b0);
    step(5'd13, 8'h00, 8'h00, 1'b0);

    // R3: binary add corners
    step(5'd1, 8'h40, 8'h40, 1'b0);
    step(5'd1, 8'hFF, 8'h01, 1'b0);
    step(5'd1, 8'h01, 8'h01, 1'b0);
    step(5'd18, 8'h00, 8'h00, 1'b0);

    // R4: binary subtract
    step(5'd12, 8'h00, 8'h00, 1'b0);
    step(5'd2, 8'h05, 8'h03, 1'b0);
    step(5'd2, 8'h03, 8'h05, 1'b0);
    step(5'd2, 8'h80, 8'h01, 1'b0);

    // R5: decimal mode
    step(5'd16, 8'h00, 8'h00, 1'b0);
    step(5'd13, 8'h00, 8'h00, 1'b0);
    step(5'd1, 8'h58, 8'h46, 1'b0);
    step(5'd1, 8'h12, 8'h34, 1'b0);
    step(5'd12, 8'h00, 8'h00, 1'b0);
    step(5'd2, 8'h12, 8'h21, 1'b0);
    step(5'd2, 8'h50, 8'h49, 1'b0);
    step(5'd17, 8'h00, 8'h00, 1'b0);

    // R6: logic functions
    step(5'd3, 8'hF0, 8'h0F, 1'b0);
    step(5'd4, 8'h80, 8'h01, 1'b0);
    step(5'd5, 8'hAA, 8'hFF, 1'b0);

    // R7: shifts and rotates
    step(5'd6, 8'h81, 8'h00, 1'b0);
    step(5'd8, 8'h40, 8'h00, 1'b0);
    step(5'd9, 8'h02, 8'h00, 1'b0);
    step(5'd12, 8'h00, 8'h00, 1'b0);
    step(5'd9, 8'h01, 8'h00, 1'b0);
    step(5'd7, 8'hFF, 8'h00, 1'b0);

    // R8: compare
    step(5'd10, 8'h10, 8'h10, 1'b0);
    step(5'd10, 8'h10, 8'h20, 1'b0);
    step(5'd10, 8'hF0, 8'h01, 1'b0);

    // R9: bit test
    step(5'd11, 8'h0F, 8'hC0, 1'b0);
    step(5'd11, 8'h01, 8'h41, 1'b0);

    // R11 and R2: status load discards bits 5 and 4
    step(5'd19, 8'h00, 8'hFF, 1'b0);
    step(5'd19, 8'h00, 8'h00, 1'b0);
    step(5'd19, 8'h00, 8'h10, 1'b0);

    // R12: pushed byte with and without break marker
    step(5'd20, 8'h00, 8'h00, 1'b1);
    step(5'd20, 8'h00, 8'h00, 1'b0);

    // Mixed random sequence against the reference model
    for (int k = 0; k < 600; k++) begin
      logic [4:0] op;
      bit [7:0] a, b;
      op = 5'($urandom_range(0, 23));
      a = 8'($urandom);
      b = 8'($urandom);
      if (m_d) begin
        a = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
        b = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
      end
      // PULL with D set would leave a random D; stays consistent via the branch above
      step(op, a, b, 1'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule